// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block sends asynchronous serial frames on a single line. The host writes a byte into a holding register. On a bit-rate enable pulse the byte moves into a shift register, which places it on the line as a frame. A frame is a low start bit, then 7 or 8 data bits least-significant first, then an optional check bit, then one or two high stop bits. The check bit is an even or odd parity bit, or a multiprocessor bit taken from a control input. Each bit lasts from one bit-rate pulse to the next. The line output comes straight from a register.

Two flags report progress. The empty flag is high while the holding register can accept a new byte. The end flag is high when the line has gone idle with nothing queued. The block looks at the empty flag at the pulse that starts the first stop bit. If a byte is waiting at that pulse, it is taken at once and its start bit follows the last stop bit with no gap. If nothing is waiting, the end flag is raised and the line stays high afterwards. Each flag drives an interrupt request line through its own enable input. Pulling the enable input low stops the transmitter: any frame in progress is dropped and the block returns to its idle state.

Top module: `ser_tx_dbuf`

## Requirements
- R1: While `rstN` is low or `txEnable` is low, `txLine` is 1, `emptyFlag` is 1 and `endFlag` is 1. Dropping `txEnable` in the middle of a frame abandons that frame. Writes made while `txEnable` is low are ignored, so no frame starts once the transmitter is enabled again.
- R2: With `txEnable` high, a cycle with `wrValid` high stores `wrData` in the holding register. From the next cycle `emptyFlag` and `endFlag` read 0.
- R3: While the line is idle and `emptyFlag` is 0, the next `bitTick` loads the shift register. At that same pulse `txLine` goes to 0 (start bit) and `emptyFlag` goes back to 1.
- R4: The data bits follow the start bit least-significant first. There are 8 data bits when `cfgSevenBit`=0. There are 7 when `cfgSevenBit`=1, and then bit 7 of the data is not sent.
- R5: When `cfgParityEn`=1 and `cfgMpMode`=0, one parity bit follows the data bits. With `cfgParityOdd`=0 the count of ones in the sent data bits plus the parity bit is even. With `cfgParityOdd`=1 that count is odd.
- R6: When `cfgMpMode`=1, one bit follows the data bits whatever the setting of `cfgParityEn`. Its value is `mpBitIn` as sampled at the moment the byte is moved into the shift register.
- R7: After the data bits and any check bit, one stop bit at 1 is sent when `cfgTwoStop`=0. Two stop bits at 1 are sent when `cfgTwoStop`=1.
- R8: If `emptyFlag` is 0 at the pulse that starts the first stop bit, the waiting byte is moved into the shift register and `emptyFlag` becomes 1 at that pulse. `endFlag` stays 0. The start bit of the next frame goes out at the pulse that ends the last stop bit.
- R9: If `emptyFlag` is 1 at the pulse that starts the first stop bit, `endFlag` becomes 1 at that pulse. After the stop bits `txLine` stays at 1.
- R10: `emptyIrq` equals `emptyIeEn AND emptyFlag AND txEnable`. `endIrq` equals `endIeEn AND endFlag AND txEnable`.
- R11: `txLine` changes only on a cycle with `bitTick` high. Between pulses it holds its value, even when the host writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| txEnable | input | 1 | Transmitter enable; low forces the idle state |
| bitTick | input | 1 | One-cycle bit-rate enable pulse |
| wrValid | input | 1 | Host write strobe for the holding register |
| wrData | input | DATA_W | Byte written to the holding register |
| mpBitIn | input | 1 | Multiprocessor bit value, sampled when a byte is moved to the shift register |
| cfgSevenBit | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| cfgParityEn | input | 1 | Adds a parity bit |
| cfgParityOdd | input | 1 | 1 selects odd parity, 0 even |
| cfgMpMode | input | 1 | Sends the multiprocessor bit in place of parity |
| cfgTwoStop | input | 1 | 1 selects two stop bits |
| emptyIeEn | input | 1 | Enable for the empty interrupt request |
| endIeEn | input | 1 | Enable for the end interrupt request |
| txLine | output | 1 | Serial output, high when idle |
| emptyFlag | output | 1 | Holding register can accept a byte |
| endFlag | output | 1 | Line idle with nothing queued |
| emptyIrq | output | 1 | Empty interrupt request |
| endIrq | output | 1 | End interrupt request |

## Verification
The bench sends frames with different data patterns and framing settings. Asymmetric and single-one bytes show whether the bit order is correct. A byte with bit 7 set, sent in 7-bit mode, shows whether the top bit is dropped and whether it is wrongly counted in the parity. Each parity sense, and the multiprocessor bit with parity also enabled, are run against both a set and a clear expected check bit. The multiprocessor input is changed after the byte has been moved, which shows whether the value was captured at the right moment. Two frames are sent, one queued while the first is on the line and one after idle. Comparing them separates the gapless path decided at the stop bit from the path that raises the end flag. A frame abandoned part way, together with a write while disabled, shows that disabling clears both the frame and the queue.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP1,
    ST_STOP2
  } txState_e;

  typedef enum logic [1:0] {
    SEL_MARK,
    SEL_START,
    SEL_DATA,
    SEL_PAR
  } lineSel_e;

  typedef struct packed {
    logic     lineUpd;
    lineSel_e sel;
    logic     loadShift;
    logic     forceMark;
  } txStrobe_t;

endpackage

// File: rtl/ser_tx_dp.sv
module ser_tx_dp
  import ser_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strb,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              mpBitIn,
  input  logic              cfgSevenBit,
  input  logic              cfgParityOdd,
  input  logic              cfgMpMode,
  output logic              txLine
);

  localparam logic [DATA_W-1:0] FULL_MASK  = '1;
  localparam logic [DATA_W-1:0] SHORT_MASK = FULL_MASK >> 1;

  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] shiftReg;
  logic              parBit;
  logic [DATA_W-1:0] dataMask;
  logic              nextParity;

  assign dataMask   = cfgSevenBit ? SHORT_MASK : FULL_MASK;
  assign nextParity = cfgMpMode ? mpBitIn : ((^(holdReg & dataMask)) ^ cfgParityOdd);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg <= '0;
    end else if (wrEn) begin
      holdReg <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else if (strb.loadShift) begin
      shiftReg <= holdReg;
      parBit   <= nextParity;
    end else if (strb.lineUpd && strb.sel == SEL_DATA) begin
      shiftReg <= shiftReg >> 1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txLine <= 1'b1;
    end else if (strb.forceMark) begin
      txLine <= 1'b1;
    end else if (strb.lineUpd) begin
      case (strb.sel)
        SEL_START: txLine <= 1'b0;
        SEL_DATA:  txLine <= shiftReg[0];
        SEL_PAR:   txLine <= parBit;
        default:   txLine <= 1'b1;
      endcase
    end
  end

  // R4
  shift_on_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.lineUpd && strb.sel == SEL_DATA && !strb.loadShift && !strb.forceMark)
      |=> txLine == $past(shiftReg[0]));

endmodule

// File: rtl/ser_tx_ctl.sv
module ser_tx_ctl
  import ser_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      txEnable,
  input  logic      bitTick,
  input  logic      wrValid,
  input  logic      cfgSevenBit,
  input  logic      cfgParityEn,
  input  logic      cfgMpMode,
  input  logic      cfgTwoStop,
  output txStrobe_t strb,
  output logic      emptyFlag,
  output logic      endFlag,
  output txState_e  state
);

  localparam int CNT_W = $clog2(DATA_W + 1);

  txState_e         stateN;
  logic [CNT_W-1:0] cnt, cntN;
  logic             pending, pendingN;
  logic             doLoad, setEnd, lineUpd;
  lineSel_e         sel;
  logic             goStop, goLeave;
  logic [CNT_W-1:0] nBits;
  logic             hasCheck;
  logic             tickEn;

  assign tickEn   = txEnable & bitTick;
  assign nBits    = cfgSevenBit ? CNT_W'(DATA_W - 1) : CNT_W'(DATA_W);
  assign hasCheck = cfgParityEn | cfgMpMode;

  always_comb begin
    stateN   = state;
    cntN     = cnt;
    pendingN = pending;
    doLoad   = 1'b0;
    setEnd   = 1'b0;
    lineUpd  = 1'b0;
    sel      = SEL_MARK;
    goStop   = 1'b0;
    goLeave  = 1'b0;
    if (tickEn) begin
      lineUpd = 1'b1;
      case (state)
        ST_IDLE: begin
          if (!emptyFlag) begin
            doLoad = 1'b1;
            sel    = SEL_START;
            stateN = ST_START;
          end
        end
        ST_START: begin
          sel    = SEL_DATA;
          cntN   = CNT_W'(1);
          stateN = ST_DATA;
        end
        ST_DATA: begin
          if (cnt < nBits) begin
            sel  = SEL_DATA;
            cntN = cnt + CNT_W'(1);
          end else if (hasCheck) begin
            sel    = SEL_PAR;
            stateN = ST_PAR;
          end else begin
            goStop = 1'b1;
          end
        end
        ST_PAR:   goStop = 1'b1;
        ST_STOP1: begin
          if (cfgTwoStop) begin
            sel    = SEL_MARK;
            stateN = ST_STOP2;
          end else begin
            goLeave = 1'b1;
          end
        end
        ST_STOP2: goLeave = 1'b1;
        default:  stateN = ST_IDLE;
      endcase
      if (goStop) begin
        sel    = SEL_MARK;
        stateN = ST_STOP1;
        if (!emptyFlag) begin
          doLoad   = 1'b1;
          pendingN = 1'b1;
        end else begin
          setEnd   = 1'b1;
          pendingN = 1'b0;
        end
      end
      if (goLeave) begin
        if (pending) begin
          sel    = SEL_START;
          stateN = ST_START;
        end else begin
          sel    = SEL_MARK;
          stateN = ST_IDLE;
        end
        pendingN = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      pending   <= 1'b0;
      emptyFlag <= 1'b1;
      endFlag   <= 1'b1;
    end else if (!txEnable) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      pending   <= 1'b0;
      emptyFlag <= 1'b1;
      endFlag   <= 1'b1;
    end else begin
      state   <= stateN;
      cnt     <= cntN;
      pending <= pendingN;
      if (wrValid) begin
        emptyFlag <= 1'b0;
        endFlag   <= 1'b0;
      end else begin
        if (doLoad) emptyFlag <= 1'b1;
        if (setEnd) endFlag <= 1'b1;
      end
    end
  end

  always_comb begin
    strb.lineUpd   = lineUpd;
    strb.sel       = sel;
    strb.loadShift = doLoad;
    strb.forceMark = !txEnable;
  end

  // R2
  wr_clears_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txEnable && wrValid) |=> (!emptyFlag && !endFlag));

  // R3
  load_sets_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doLoad && !wrValid) |=> emptyFlag);

  // R9
  end_at_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(endFlag) && $past(txEnable)) |-> state == ST_STOP1);

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_W'(DATA_W));

  // R11
  state_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!bitTick && txEnable) |=> $stable(state));

endmodule

// File: rtl/ser_tx_dbuf.sv
module ser_tx_dbuf
  import ser_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txEnable,
  input  logic              bitTick,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  input  logic              mpBitIn,
  input  logic              cfgSevenBit,
  input  logic              cfgParityEn,
  input  logic              cfgParityOdd,
  input  logic              cfgMpMode,
  input  logic              cfgTwoStop,
  input  logic              emptyIeEn,
  input  logic              endIeEn,
  output logic              txLine,
  output logic              emptyFlag,
  output logic              endFlag,
  output logic              emptyIrq,
  output logic              endIrq
);

  txStrobe_t strb;
  txState_e  state;
  logic      wrEn;

  assign wrEn = txEnable & wrValid;

  ser_tx_ctl #(.DATA_W(DATA_W)) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .txEnable   (txEnable),
    .bitTick    (bitTick),
    .wrValid    (wrValid),
    .cfgSevenBit(cfgSevenBit),
    .cfgParityEn(cfgParityEn),
    .cfgMpMode  (cfgMpMode),
    .cfgTwoStop (cfgTwoStop),
    .strb       (strb),
    .emptyFlag  (emptyFlag),
    .endFlag    (endFlag),
    .state      (state)
  );

  ser_tx_dp #(.DATA_W(DATA_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wrEn        (wrEn),
    .wrData      (wrData),
    .mpBitIn     (mpBitIn),
    .cfgSevenBit (cfgSevenBit),
    .cfgParityOdd(cfgParityOdd),
    .cfgMpMode   (cfgMpMode),
    .txLine      (txLine)
  );

  assign emptyIrq = emptyIeEn & emptyFlag & txEnable;
  assign endIrq   = endIeEn & endFlag & txEnable;

  // R1
  disabled_mark_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txEnable |=> (txLine && emptyFlag && endFlag));

  // R3
  start_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_START) |-> !txLine);

  // R11
  line_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!bitTick && txEnable) |=> $stable(txLine));

  // R9
  idle_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> txLine);

endmodule

// File: tb/sim_ser_tx_dbuf.sv
module sim_ser_tx_dbuf;

  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txEnable = 1'b0;
  logic bitTick = 1'b0;
  logic wrValid = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic mpBitIn = 1'b0;
  logic cfgSevenBit = 1'b0, cfgParityEn = 1'b0, cfgParityOdd = 1'b0;
  logic cfgMpMode = 1'b0, cfgTwoStop = 1'b0;
  logic emptyIeEn = 1'b0, endIeEn = 1'b0;
  logic txLine, emptyFlag, endFlag, emptyIrq, endIrq;

  int testsRun = 0;
  int failCnt = 0;

  always #2 clk = ~clk;

  ser_tx_dbuf #(.DATA_W(DATA_W)) u0 (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .bitTick(bitTick),
    .wrValid(wrValid), .wrData(wrData), .mpBitIn(mpBitIn),
    .cfgSevenBit(cfgSevenBit), .cfgParityEn(cfgParityEn),
    .cfgParityOdd(cfgParityOdd), .cfgMpMode(cfgMpMode),
    .cfgTwoStop(cfgTwoStop), .emptyIeEn(emptyIeEn), .endIeEn(endIeEn),
    .txLine(txLine), .emptyFlag(emptyFlag), .endFlag(endFlag),
    .emptyIrq(emptyIrq), .endIrq(endIrq)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) bitTick = 1'b1;
    @(negedge clk) bitTick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic hostWrite(input logic [DATA_W-1:0] d);
    @(negedge clk) begin wrValid = 1'b1; wrData = d; end
    @(negedge clk) wrValid = 1'b0;
  endtask

  // Sends one frame whose byte is already queued or loaded; checks every bit.
  task automatic sendFrame(input logic [DATA_W-1:0] d, input logic mpv, input logic expEnd,
                           input logic doWrite, input logic [DATA_W-1:0] nextD, input string tag);
    logic [15:0] bits;
    int n, nb, stopIdx;
    logic par;
    bits = '0;
    n = 0;
    nb = cfgSevenBit ? DATA_W - 1 : DATA_W;
    bits[n] = 1'b0; n++;
    par = cfgParityOdd;
    for (int i = 0; i < nb; i++) begin
      bits[n] = d[i]; n++;
      par = par ^ d[i];
    end
    if (cfgMpMode) begin bits[n] = mpv; n++; end
    else if (cfgParityEn) begin bits[n] = par; n++; end
    stopIdx = n;
    bits[n] = 1'b1; n++;
    if (cfgTwoStop) begin bits[n] = 1'b1; n++; end
    for (int k = 0; k < n; k++) begin
      tick();
      check(txLine == bits[k], $sformatf("%s R4 R5 R6 R7 bit %0d", tag, k), txLine, bits[k]);
      if (k == 0) begin
        check(emptyFlag == 1'b1, {tag, " R3 empty after transfer"}, emptyFlag, 1);
        if (cfgMpMode) mpBitIn = ~mpv;
        if (doWrite) hostWrite(nextD);
      end
      if (k == stopIdx) begin
        check(endFlag == expEnd, {tag, " R8 R9 end flag at stop"}, endFlag, expEnd);
        check(emptyFlag == 1'b1, {tag, " R8 empty at stop"}, emptyFlag, 1);
      end
    end
  endtask

  task automatic expectIdle(input string tag);
    tick();
    check(txLine == 1'b1, {tag, " R9 mark after frame"}, txLine, 1);
    check(endFlag == 1'b1, {tag, " R9 end flag held"}, endFlag, 1);
  endtask

  task automatic tReset();
    check(txLine == 1'b1, "R1 reset line", txLine, 1);
    check(emptyFlag == 1'b1 && endFlag == 1'b1, "R1 reset flags", {emptyFlag, endFlag}, 3);
    emptyIeEn = 1'b1; endIeEn = 1'b1;
    @(negedge clk);
    check(emptyIrq == 1'b0 && endIrq == 1'b0, "R10 irq gated by disable", {emptyIrq, endIrq}, 0);
    txEnable = 1'b1;
    @(negedge clk);
    check(emptyIrq == 1'b1 && endIrq == 1'b1, "R10 irq both enabled", {emptyIrq, endIrq}, 3);
    emptyIeEn = 1'b0;
    @(negedge clk);
    check(emptyIrq == 1'b0 && endIrq == 1'b1, "R10 empty irq masked", {emptyIrq, endIrq}, 1);
    endIeEn = 1'b0;
    @(negedge clk);
    check(endIrq == 1'b0, "R10 end irq masked", endIrq, 0);
  endtask

  task automatic tHoldNoTick();
    hostWrite(8'h3C);
    repeat (6) @(negedge clk);
    check(txLine == 1'b1, "R11 line holds without tick", txLine, 1);
    check(emptyFlag == 1'b0 && endFlag == 1'b0, "R2 write clears flags", {emptyFlag, endFlag}, 0);
    endIeEn = 1'b1; emptyIeEn = 1'b1;
    @(negedge clk);
    check(endIrq == 1'b0 && emptyIrq == 1'b0, "R10 irq follows flags", {emptyIrq, endIrq}, 0);
    endIeEn = 1'b0; emptyIeEn = 1'b0;
    sendFrame(8'h3C, 1'b0, 1'b1, 1'b0, '0, "8N1 3C");
    expectIdle("8N1 3C");
  endtask

  task automatic tPatterns();
    hostWrite(8'hA5); sendFrame(8'hA5, 1'b0, 1'b1, 1'b0, '0, "8N1 A5"); expectIdle("A5");
    hostWrite(8'h01); sendFrame(8'h01, 1'b0, 1'b1, 1'b0, '0, "8N1 01"); expectIdle("01");
    hostWrite(8'h80); sendFrame(8'h80, 1'b0, 1'b1, 1'b0, '0, "8N1 80"); expectIdle("80");
  endtask

  task automatic tParity();
    cfgSevenBit = 1'b1; cfgParityEn = 1'b1; cfgParityOdd = 1'b0;
    hostWrite(8'hFF); sendFrame(8'hFF, 1'b0, 1'b1, 1'b0, '0, "7E1 FF"); expectIdle("7E1");
    hostWrite(8'h03); sendFrame(8'h03, 1'b0, 1'b1, 1'b0, '0, "7E1 03"); expectIdle("7E1b");
    cfgSevenBit = 1'b0; cfgParityOdd = 1'b1; cfgTwoStop = 1'b1;
    hostWrite(8'h0F); sendFrame(8'h0F, 1'b0, 1'b1, 1'b0, '0, "8O2 0F"); expectIdle("8O2");
    hostWrite(8'h07); sendFrame(8'h07, 1'b0, 1'b1, 1'b0, '0, "8O2 07"); expectIdle("8O2b");
    cfgParityEn = 1'b0; cfgParityOdd = 1'b0; cfgTwoStop = 1'b0;
  endtask

  task automatic tMpBit();
    cfgMpMode = 1'b1; cfgParityEn = 1'b1;
    hostWrite(8'h00);
    mpBitIn = 1'b1;
    sendFrame(8'h00, 1'b1, 1'b1, 1'b0, '0, "R6 mp1"); expectIdle("mp1");
    hostWrite(8'hFF);
    mpBitIn = 1'b0;
    sendFrame(8'hFF, 1'b0, 1'b1, 1'b0, '0, "R6 mp0"); expectIdle("mp0");
    cfgMpMode = 1'b0; cfgParityEn = 1'b0;
  endtask

  task automatic tBackToBack();
    hostWrite(8'h55);
    sendFrame(8'h55, 1'b0, 1'b0, 1'b1, 8'hC3, "R8 first");
    sendFrame(8'hC3, 1'b0, 1'b1, 1'b0, '0, "R8 second");
    expectIdle("R8 tail");
    cfgTwoStop = 1'b1;
    hostWrite(8'h96);
    sendFrame(8'h96, 1'b0, 1'b0, 1'b1, 8'h69, "R8 2stop first");
    sendFrame(8'h69, 1'b0, 1'b1, 1'b0, '0, "R8 2stop second");
    expectIdle("R8 2stop tail");
    cfgTwoStop = 1'b0;
  endtask

  task automatic tDisable();
    hostWrite(8'h00);
    tick();
    check(txLine == 1'b0, "R3 start before abort", txLine, 0);
    tick();
    @(negedge clk) txEnable = 1'b0;
    @(negedge clk);
    check(txLine == 1'b1, "R1 line forced high", txLine, 1);
    check(emptyFlag == 1'b1 && endFlag == 1'b1, "R1 flags forced", {emptyFlag, endFlag}, 3);
    hostWrite(8'h00);
    check(emptyFlag == 1'b1, "R1 write ignored while disabled", emptyFlag, 1);
    @(negedge clk) txEnable = 1'b1;
    tick();
    check(txLine == 1'b1, "R1 no frame after re-enable", txLine, 1);
    tick();
    check(txLine == 1'b1 && emptyFlag == 1'b1, "R1 frame abandoned", txLine, 1);
  endtask

  initial begin
    #(200000 * 4);
    failCnt++;
    testsRun++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", testsRun, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tHoldNoTick();
    tPatterns();
    tParity();
    tMpBit();
    tBackToBack();
    tDisable();
    $display("[TB] %0d tests run, %0d failed", testsRun, failCnt);
    $finish;
  end

endmodule